// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned operands and reports whether the first is greater than, less than or equal to the second. Each result is a separate flag. The basic element is a 4-bit stage. Besides its two nibbles, a stage takes three relation inputs from the stage below it, which is the stage that handles the next less significant nibble. A stage settles the result from its own nibbles whenever they differ. Only when its nibbles match does it pass on the relation it received from below.

The top level is a chain of such stages, sized by a parameter. Stage 0 takes the lowest nibble and receives its relation from the top-level cascade ports. The result of each stage feeds the stage above it. The flags of the highest stage are the outputs of the block. To compare words wider than one chain, tie the cascade ports of the lowest chain to "equal". To extend a compare over several chains, drive them from a lower chain instead. The block is purely combinational: it has no clock, no reset and no state.

Top module: `mag_cmp_chain`

## Requirements
- R1: When the operands of a stage differ and its A nibble is the larger, the stage drives greater=1, less=0, equal=0, whatever its cascade inputs carry.
- R2: When the operands of a stage differ and its A nibble is the smaller, the stage drives greater=0, less=1, equal=0, whatever its cascade inputs carry.
- R3: When the nibbles of a stage are equal, its three outputs copy its three cascade inputs bit for bit. This holds for every combination of cascade inputs, including combinations that are not one-hot.
- R4: When the cascade inputs are one-hot, exactly one of the greater, less and equal outputs is 1.
- R5: Stage k handles operand bits [4k+3:4k], and its result drives the cascade inputs of stage k+1. The most significant nibble position at which the operands differ decides the result, whatever the lower nibbles hold.
- R6: With cascade inputs greater=0, less=0, equal=1, the outputs of a chain of N stages match an unsigned comparison of the full 4N-bit operands.
- R7: When the full operands are equal, the outputs of the chain copy the external cascade ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | NIB_W*N_STAGES | Operand A, unsigned |
| b_i | input | NIB_W*N_STAGES | Operand B, unsigned |
| casc_gt_i | input | 1 | Lower-order result: A greater |
| casc_lt_i | input | 1 | Lower-order result: A less |
| casc_eq_i | input | 1 | Lower-order result: equal |
| gt_o | output | 1 | A greater than B |
| lt_o | output | 1 | A less than B |
| eq_o | output | 1 | A equal to B, or cascade passed through |

## Verification
The two functions that can act at once are the local nibble decision and the cascade pass-through. A high stage can have equal nibbles and forward its input, while a lower stage decides on its own nibbles and ignores the external cascade. The bench sets this up with operands whose upper nibbles agree and whose lowest nibble differs, and drives an external cascade value that contradicts the true order. It judges the result by checking that the lower stage's decision reaches the outputs and that the cascade value does not. An exhaustive sweep of a one-stage chain over all operand pairs and all eight cascade codes covers the boundary between the two functions.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } rel_t;
endpackage

// File: rtl/nibble_cmp.sv
module nibble_cmp
  import mag_cmp_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output rel_t         rel_o
);
  // pre_eq[i]: bits above i all match
  logic [W:0]   pre_eq;
  logic [W-1:0] gt_bit;
  logic [W-1:0] lt_bit;

  assign pre_eq[W] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pre_eq[i] = pre_eq[i+1] & (a_i[i] ~^ b_i[i]);
    assign gt_bit[i] = pre_eq[i+1] & a_i[i] & ~b_i[i];
    assign lt_bit[i] = pre_eq[i+1] & ~a_i[i] & b_i[i];
  end

  assign rel_o.gt = |gt_bit;
  assign rel_o.lt = |lt_bit;
  assign rel_o.eq = pre_eq[0];
endmodule

// File: rtl/cascade_merge.sv
module cascade_merge
  import mag_cmp_pkg::*;
(
  input  rel_t local_i,
  input  rel_t casc_i,
  output rel_t rel_o
);
  assign rel_o = local_i.eq ? casc_i : local_i;
endmodule

// File: rtl/mag_cmp_stage.sv
module mag_cmp_stage
  import mag_cmp_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  rel_t         casc_i,
  output rel_t         rel_o
);
  rel_t local_rel;

  nibble_cmp #(.W(W)) u_cmp (
    .a_i  (a_i),
    .b_i  (b_i),
    .rel_o(local_rel)
  );

  cascade_merge u_merge (
    .local_i(local_rel),
    .casc_i (casc_i),
    .rel_o  (rel_o)
  );
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned N_STAGES = 4,
  localparam int unsigned WORD_W  = NIB_W * N_STAGES
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              casc_gt_i,
  input  logic              casc_lt_i,
  input  logic              casc_eq_i,
  output logic              gt_o,
  output logic              lt_o,
  output logic              eq_o
);
  rel_t link [N_STAGES+1];

  assign link[0] = '{gt: casc_gt_i, lt: casc_lt_i, eq: casc_eq_i};

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    mag_cmp_stage #(.W(NIB_W)) u_stage (
      .a_i   (a_i[k*NIB_W +: NIB_W]),
      .b_i   (b_i[k*NIB_W +: NIB_W]),
      .casc_i(link[k]),
      .rel_o (link[k+1])
    );
  end

  assign gt_o = link[N_STAGES].gt;
  assign lt_o = link[N_STAGES].lt;
  assign eq_o = link[N_STAGES].eq;
endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic              casc_gt_i,
  input logic              casc_lt_i,
  input logic              casc_eq_i,
  input logic              gt_o,
  input logic              lt_o,
  input logic              eq_o
);
  always_comb begin
    if (a_i > b_i) begin
      p_gt_excl_r1: assert (gt_o && !lt_o && !eq_o)
        else $error("greater flag set wrong");
    end
    if (a_i < b_i) begin
      p_lt_excl_r2: assert (!gt_o && lt_o && !eq_o)
        else $error("less flag set wrong");
    end
    if (a_i == b_i) begin
      p_casc_copy_r7: assert ({gt_o, lt_o, eq_o} == {casc_gt_i, casc_lt_i, casc_eq_i})
        else $error("cascade not passed through");
    end
    if ($onehot({casc_gt_i, casc_lt_i, casc_eq_i})) begin
      p_onehot_out_r4: assert ($onehot({gt_o, lt_o, eq_o}))
        else $error("outputs not one-hot");
    end
  end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WORD_W(WORD_W)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .casc_gt_i(casc_gt_i),
  .casc_lt_i(casc_lt_i),
  .casc_eq_i(casc_eq_i),
  .gt_o     (gt_o),
  .lt_o     (lt_o),
  .eq_o     (eq_o)
);

// File: tb/tb_mag_cmp_chain.sv
module tb_mag_cmp_chain;
  localparam int unsigned NW = 4;
  localparam int unsigned NS = 4;
  localparam int unsigned WW = NW * NS;

  typedef struct packed {
    logic [WW-1:0] a;
    logic [WW-1:0] b;
    logic [2:0]    casc;  // {gt,lt,eq}
    logic [2:0]    exp;   // {gt,lt,eq}
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{16'h0000, 16'h0000, 3'b001, 3'b001},  // R7
    '{16'h0000, 16'h0000, 3'b100, 3'b100},  // R7
    '{16'h0000, 16'h0000, 3'b010, 3'b010},  // R7
    '{16'hFFFF, 16'hFFFF, 3'b000, 3'b000},  // R3 non-one-hot copy
    '{16'h8000, 16'h7FFF, 3'b001, 3'b100},  // R5 top nibble decides
    '{16'h7FFF, 16'h8000, 3'b001, 3'b010},  // R5
    '{16'h1234, 16'h1235, 3'b100, 3'b010},  // R2 cascade ignored
    '{16'h1235, 16'h1234, 3'b010, 3'b100},  // R1 cascade ignored
    '{16'hA5A5, 16'hA5A5, 3'b011, 3'b011},  // R3
    '{16'hFFFE, 16'hFFFF, 3'b001, 3'b010}   // R6
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [WW-1:0] a, b;
  logic cg, cl, ce;
  logic gt, lt, eq;

  logic [NW-1:0] a1, b1;
  logic cg1, cl1, ce1;
  logic gt1, lt1, eq1;

  mag_cmp_chain #(.NIB_W(NW), .N_STAGES(NS)) dut (
    .a_i(a), .b_i(b), .casc_gt_i(cg), .casc_lt_i(cl), .casc_eq_i(ce),
    .gt_o(gt), .lt_o(lt), .eq_o(eq)
  );

  mag_cmp_chain #(.NIB_W(NW), .N_STAGES(1)) dut_one (
    .a_i(a1), .b_i(b1), .casc_gt_i(cg1), .casc_lt_i(cl1), .casc_eq_i(ce1),
    .gt_o(gt1), .lt_o(lt1), .eq_o(eq1)
  );

  function automatic logic [2:0] model(logic [WW-1:0] x, logic [WW-1:0] y, logic [2:0] c);
    if (x > y) return 3'b100;
    if (x < y) return 3'b010;
    return c;
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic drive(logic [WW-1:0] x, logic [WW-1:0] y, logic [2:0] c);
    @(negedge clk);
    a = x; b = y; {cg, cl, ce} = c;
    #1;
  endtask

  initial begin
    a = '0; b = '0; {cg, cl, ce} = 3'b001;
    a1 = '0; b1 = '0; {cg1, cl1, ce1} = 3'b001;

    // idle state: equal operands with tied cascade report equal (R7)
    #2;
    check("R7 idle", {gt, lt, eq}, 3'b001);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].a, VEC[i].b, VEC[i].casc);
      check("R5 table", {gt, lt, eq}, VEC[i].exp);
    end

    // single stage: every nibble pair with every cascade code (R1 R2 R3 R4)
    for (int c = 0; c < 8; c++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          a1 = 4'(x); b1 = 4'(y); {cg1, cl1, ce1} = 3'(c);
          #1;
          if (x > y)       check("R1 stage", {gt1, lt1, eq1}, 3'b100);
          else if (x < y)  check("R2 stage", {gt1, lt1, eq1}, 3'b010);
          else             check("R3 stage", {gt1, lt1, eq1}, 3'(c));
          if (c == 1 || c == 2 || c == 4) begin
            checks++;
            if ($countones({gt1, lt1, eq1}) != 1) begin
              errors++;
              $display("FAIL R4 act=%b exp=one-hot", {gt1, lt1, eq1});
            end
          end
        end
      end
    end

    // chain: random full-width pairs, tied cascade (R6)
    for (int i = 0; i < 3000; i++) begin
      logic [WW-1:0] x, y;
      x = WW'($urandom);
      y = WW'($urandom);
      drive(x, y, 3'b001);
      check("R6 random", {gt, lt, eq}, model(x, y, 3'b001));
    end

    // chain: one nibble altered, contradicting cascade; lower decision must win (R5 R7)
    for (int i = 0; i < 2000; i++) begin
      logic [WW-1:0] x, y;
      logic [2:0] c;
      int k;
      x = WW'($urandom);
      k = int'($urandom_range(NS - 1, 0));
      y = x;
      y[k*NW +: NW] = NW'($urandom);
      c = 3'($urandom);
      drive(x, y, c);
      check("R5 nibble", {gt, lt, eq}, model(x, y, c));
    end

    // boundary words
    drive('1, '0, 3'b010);
    check("R1 max-min", {gt, lt, eq}, 3'b100);
    drive('0, '1, 3'b100);
    check("R2 min-max", {gt, lt, eq}, 3'b010);
    drive(16'h0001, 16'h0000, 3'b010);
    check("R5 lsb only", {gt, lt, eq}, 3'b100);
    drive(16'h5555, 16'h5555, 3'b111);
    check("R7 all set", {gt, lt, eq}, 3'b111);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule